// File: doc/BRIEF.md
# Arithmetic Shift-Right-by-Immediate Execution Unit

This unit takes one 32-bit instruction word together with the 64-bit value of the register it names as source. It recognises the arithmetic shift-right-by-immediate doubleword operation and computes the sign-filled result and the carry bit. When the record flag is set, it also forms a signed condition field. The register file, the carry and overflow storage, the pipeline and every other operation stay outside the unit. The unit reports the register indices it decodes, so the surrounding datapath can fetch the operand and write the result back.

Instruction bits are numbered big-endian: instruction bit n is `insn_i[31-n]`. The shift count is split across two fields that are not adjacent, so the unit first gathers it into 6 bits. Decode and execution are combinational. All outputs are captured in registers, and they present the result one clock after the valid strobe.

Top module: `asr_imm_unit`

## Requirements
- R1: The word matches when instruction bits 0–5 hold 31 and bits 21–29 hold 413, which is the word 0x7C000674 with all operand fields zero. For a strobed word that does not match, `nomatch_o` is 1 and `res_o`, `ca_o`, `cr_o` and `cr_we_o` are all 0. For a matched word, `nomatch_o` is 0.
- R2: `src_idx_o` holds instruction bits 6–10 and `dst_idx_o` holds bits 11–15. In each field the lower-numbered bit is the most significant.
- R3: The shift count is 6 bits, 0 to 63. Instruction bit 30 is its most significant bit and bits 16–20 are its low five bits. `res_o` is the source shifted right by this count, with each vacated upper bit filled with the source sign bit.
- R4: `ca_o` is 1 exactly when the source is negative and at least one 1-bit leaves the low end during the shift. Any other matched execution writes 0.
- R5: A shift count of 0 returns the source unchanged and forces `ca_o` to 0.
- R6: When instruction bit 31 is 1 and the word matches, `cr_we_o` is 1 and `cr_o` = {LT, GT, EQ, SO}, most significant bit first. LT, GT and EQ come from a signed compare of the result with zero, and exactly one of them is set. SO copies `so_i`. In every other case `cr_we_o` and `cr_o` are 0.
- R7: A strobe on `valid_i` loads all outputs at the next rising clock edge, and `vld_o` is 1 for that one cycle. While `valid_i` is low, the data outputs hold their values.
- R8: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Instruction strobe |
| insn_i | input | 32 | Instruction word, bit 0 of the instruction = insn_i[31] |
| src_i | input | 64 | Source register value |
| so_i | input | 1 | Current summary-overflow bit |
| vld_o | output | 1 | Outputs were loaded at the last edge |
| res_o | output | 64 | Shift result |
| ca_o | output | 1 | Carry bit |
| cr_o | output | 4 | Condition field {LT, GT, EQ, SO} |
| cr_we_o | output | 1 | Condition field must be written |
| nomatch_o | output | 1 | Word is not this operation |
| src_idx_o | output | 5 | Source register index |
| dst_idx_o | output | 5 | Destination register index |

## Verification
The bench builds the unit with its default parameters: a 64-bit datapath, primary opcode 31 and extended opcode 413. These defaults are the only values the instruction encoding allows. They bring the full 6-bit count range within reach, so every count from 0 to 63 is run on a positive, a negative, a zero and the most-negative source. Seeded random words and sources then mix record-flag and summary-overflow settings, and words with a wrong opcode field exercise the non-matching path.

// File: rtl/asr_imm_unit.sv
module asr_imm_unit #(
  parameter int XLEN   = 64,
  parameter int PRI_OP = 31,
  parameter int EXT_OP = 413
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid_i,
  input  logic [31:0]     insn_i,
  input  logic [XLEN-1:0] src_i,
  input  logic            so_i,
  output logic            vld_o,
  output logic [XLEN-1:0] res_o,
  output logic            ca_o,
  output logic [3:0]      cr_o,
  output logic            cr_we_o,
  output logic            nomatch_o,
  output logic [4:0]      src_idx_o,
  output logic [4:0]      dst_idx_o
);
  localparam int SHW = $clog2(XLEN);

  logic [SHW-1:0]  sh_amt;
  logic            hit, rec, carry, lt, eq, gt;
  logic [XLEN-1:0] shifted, lost_mask;

  assign sh_amt    = {insn_i[1], insn_i[15:11]};
  assign hit       = (insn_i[31:26] == 6'(PRI_OP)) && (insn_i[10:2] == 9'(EXT_OP));
  assign rec       = insn_i[0];
  assign shifted   = $signed(src_i) >>> sh_amt;
  assign lost_mask = ~({XLEN{1'b1}} << sh_amt);
  assign carry     = src_i[XLEN-1] & (|(src_i & lost_mask));
  assign lt        = shifted[XLEN-1];
  assign eq        = (shifted == '0);
  assign gt        = ~lt & ~eq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_o     <= 1'b0;
      res_o     <= '0;
      ca_o      <= 1'b0;
      cr_o      <= '0;
      cr_we_o   <= 1'b0;
      nomatch_o <= 1'b0;
      src_idx_o <= '0;
      dst_idx_o <= '0;
    end else begin
      vld_o <= valid_i;
      if (valid_i) begin
        nomatch_o <= ~hit;
        res_o     <= hit ? shifted : '0;
        ca_o      <= hit & carry;
        cr_we_o   <= hit & rec;
        cr_o      <= (hit & rec) ? {lt, gt, eq, so_i} : 4'b0;
        src_idx_o <= insn_i[25:21];
        dst_idx_o <= insn_i[20:16];
      end
    end
  end
endmodule

// File: rtl/asr_imm_unit_chk.sv
module asr_imm_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            valid_i,
  input logic [31:0]     insn_i,
  input logic [XLEN-1:0] src_i,
  input logic            vld_o,
  input logic [XLEN-1:0] res_o,
  input logic            ca_o,
  input logic [3:0]      cr_o,
  input logic            cr_we_o,
  input logic            nomatch_o
);
  logic zero_sh_hit;
  assign zero_sh_hit = valid_i && insn_i[31:26] == 6'd31 && insn_i[10:2] == 9'd413
                       && insn_i[1] == 1'b0 && insn_i[15:11] == 5'd0;

  AST_VLD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> vld_o); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_i && !vld_o) |=> $stable(res_o) && $stable(ca_o)); // R7
  AST_NOMATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    nomatch_o |-> (res_o == '0) && !ca_o && !cr_we_o && (cr_o == 4'b0)); // R1
  AST_POS_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && !res_o[XLEN-1]) |-> !ca_o); // R4
  AST_ZERO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    zero_sh_hit |=> (res_o == $past(src_i)) && !ca_o); // R5
  AST_CR_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we_o |-> ($countones(cr_o[3:1]) == 1) && (cr_o[3] == res_o[XLEN-1])); // R6
  AST_CR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cr_we_o |-> (cr_o == 4'b0)); // R6
endmodule

bind asr_imm_unit asr_imm_unit_chk #(.XLEN(XLEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .insn_i(insn_i), .src_i(src_i),
  .vld_o(vld_o), .res_o(res_o), .ca_o(ca_o), .cr_o(cr_o), .cr_we_o(cr_we_o),
  .nomatch_o(nomatch_o)
);

// File: tb/asr_imm_unit_tb_top.sv
module asr_imm_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic [63:0] src_i = '0;
  logic        so_i = 1'b0;
  logic        vld_o, ca_o, cr_we_o, nomatch_o;
  logic [63:0] res_o;
  logic [3:0]  cr_o;
  logic [4:0]  src_idx_o, dst_idx_o;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  asr_imm_unit dut_i (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .insn_i(insn_i), .src_i(src_i),
    .so_i(so_i), .vld_o(vld_o), .res_o(res_o), .ca_o(ca_o), .cr_o(cr_o),
    .cr_we_o(cr_we_o), .nomatch_o(nomatch_o), .src_idx_o(src_idx_o), .dst_idx_o(dst_idx_o)
  );

  function automatic logic [31:0] mk(input logic [5:0] pri, input logic [4:0] rs,
                                     input logic [4:0] ra, input logic [5:0] sh,
                                     input logic [8:0] xo, input logic rc);
    return {pri, rs, ra, sh[4:0], xo, sh[5], rc};
  endfunction

  function automatic logic [63:0] ref_res(input logic [63:0] v, input int sh);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = (i + sh > 63) ? v[63] : v[i + sh];
    return r;
  endfunction

  function automatic logic ref_ca(input logic [63:0] v, input int sh);
    logic lost = 1'b0;
    for (int i = 0; i < sh; i++) lost |= v[i];
    return v[63] & lost;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] w, input logic [63:0] v, input logic so);
    logic        match, rec;
    int          sh;
    logic [63:0] er;
    logic        ec, lt, eq;
    logic [3:0]  ecr;
    match = (w[31:26] == 6'd31) && (w[10:2] == 9'd413);
    rec   = w[0];
    sh    = {w[1], w[15:11]};
    er    = match ? ref_res(v, sh) : 64'd0;
    ec    = match ? ((sh == 0) ? 1'b0 : ref_ca(v, sh)) : 1'b0;
    lt    = $signed(er) < 0;
    eq    = (er == 0);
    ecr   = (match && rec) ? {lt, !lt && !eq, eq, so} : 4'b0;
    @(negedge clk);
    insn_i = w; src_i = v; so_i = so; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    chk(vld_o == 1'b1, "R7 vld", 64'(vld_o), 64'd1);
    chk(res_o == er, (sh == 0) ? "R5 res" : "R3 res", res_o, er);
    chk(ca_o == ec, (sh == 0) ? "R5 ca" : "R4 ca", 64'(ca_o), 64'(ec));
    chk(cr_we_o == (match && rec), "R6 cr_we", 64'(cr_we_o), 64'(match && rec));
    chk(cr_o == ecr, "R6 cr", 64'(cr_o), 64'(ecr));
    chk(nomatch_o == !match, "R1 nomatch", 64'(nomatch_o), 64'(!match));
    chk(src_idx_o == w[25:21], "R2 src_idx", 64'(src_idx_o), 64'(w[25:21]));
    chk(dst_idx_o == w[20:16], "R2 dst_idx", 64'(dst_idx_o), 64'(w[20:16]));
  endtask

  initial begin
    #(20 * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] pats [4];
    logic [63:0] keep;
    pats[0] = 64'h3A5C_0F0F_1234_ABCD;
    pats[1] = 64'hF0F0_8001_0000_0003;
    pats[2] = 64'h0;
    pats[3] = 64'h8000_0000_0000_0000;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(vld_o == 0 && res_o == 0 && ca_o == 0 && cr_o == 0 && cr_we_o == 0 && nomatch_o == 0,
        "R8 reset", res_o, 64'd0);
    rst_n = 1'b1;

    for (int s = 0; s < 64; s++)
      for (int p = 0; p < 4; p++)
        run(mk(6'd31, 5'(s), 5'(63 - s), 6'(s), 9'd413, p[0]), pats[p], s[1]);

    run(mk(6'd31, 5'd1, 5'd2, 6'd0, 9'd413, 1'b1), 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    run(mk(6'd31, 5'd1, 5'd2, 6'd63, 9'd413, 1'b1), 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    run(mk(6'd31, 5'd1, 5'd2, 6'd4, 9'd413, 1'b1), 64'hFFFF_FFFF_FFFF_FFF0, 1'b1);
    run(mk(6'd31, 5'd1, 5'd2, 6'd4, 9'd413, 1'b1), 64'hFFFF_FFFF_FFFF_FFF8, 1'b0);
    run(mk(6'd31, 5'd1, 5'd2, 6'd32, 9'd413, 1'b0), 64'h7FFF_FFFF_FFFF_FFFF, 1'b0);
    run(mk(6'd30, 5'd3, 5'd4, 6'd5, 9'd413, 1'b1), 64'hDEAD_BEEF_0000_0001, 1'b1);
    run(mk(6'd31, 5'd3, 5'd4, 6'd5, 9'd414, 1'b1), 64'hDEAD_BEEF_0000_0001, 1'b1);
    run(mk(6'd31, 5'd3, 5'd4, 6'd5, 9'd412, 1'b0), 64'h8000_0000_0000_00FF, 1'b0);

    for (int k = 0; k < 300; k++) begin
      logic [31:0] w;
      logic [63:0] v;
      w = $urandom;
      v = {$urandom, $urandom};
      if (k % 8 != 0) begin
        w[31:26] = 6'd31;
        w[10:2]  = 9'd413;
      end
      run(w, v, 1'($urandom));
    end

    keep = res_o;
    insn_i = '1; src_i = '1;
    @(negedge clk);
    @(negedge clk);
    chk(vld_o == 0 && res_o == keep, "R7 hold", res_o, keep);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule